// File: doc/BRIEF.md
# Dual-Protocol Host Register Interface

This block is a synchronous 8-bit slave on a host processor bus. One register core serves two bus styles:

- **Transfer-start style:** a start strobe, a read/write line and a burst flag, answered with an acknowledge pulse.
- **Address-strobe style:** an address-latch pulse, a separate access strobe and a write/read line, answered with a ready pulse.

A 2-bit mode input is sampled during reset and picks the style, or switches the bus off. The bus works straight out of reset, before any other setup.

The host sees a small map of dedicated registers in the lower half of a 5-bit address space:

- status, with two write-one-to-clear flags;
- control, holding the interrupt enable;
- a scratchpad;
- a readback address register, driven out of the block;
- a readback data port, read from an input;
- a fixed identification value.

The upper half of the address space is a window onto 16 registers that live in user logic. Each window access raises a one-cycle start strobe toward user logic. The host cycle stays open until user logic answers with an end pulse. If no answer comes within a bounded number of cycles, the block closes the host cycle anyway and flags the timeout. User logic can also request attention: the request always sets a pending flag the host can poll, and it drives the interrupt output only when the host has enabled it.

Top module: `hostreg_bridge`

## Requirements
- R1: `mode_sel` is captured while `rst_n` is low and ignored afterwards. 2'b01 selects the transfer-start style and 2'b10 the address-strobe style. With 2'b00 or 2'b11 no request is ever accepted: `ta_ack`, `as_ready` and `dout_oe` stay 0.
- R2: Transfer-start style. A request is captured at a rising edge where `ta_start` is 1, with `ta_rnw`=1 meaning read. `ta_ack` is then high for exactly the cycle after that edge for a dedicated register, and `as_ready` stays 0.
- R3: Address-strobe style.
  - `addr` is latched at an edge with `as_latch`=1. An access is captured at an edge with `as_strobe`=1, with `as_wnr`=1 meaning write.
  - The access uses the latched address, or the current `addr` when `as_latch` is also 1 at that edge.
  - `as_ready` pulses for the cycle after capture, and `ta_ack` stays 0. `ta_start` has no effect in this style.
- R4: The scratchpad at offset 0x02 reads 0x00 after reset and afterwards returns the last value written.
- R5: Offset 0x05 reads the `ID_VALUE` parameter (default 0x3C). Writes to it change nothing.
- R6: Reads of offsets 0x06 to 0x0F return 0x00. A transfer-start request with `ta_burst`=1 is acknowledged in the cycle after capture but writes nothing, and a read with it returns 0x00.
- R7: A request to offsets 0x10 to 0x1F raises `usr_start` for one cycle, in the cycle after capture. During that cycle `usr_addr` = address bits [3:0], `usr_wr`=1 for writes, and `usr_wdata` carries the written data. The host acknowledge follows in the cycle after the first edge that sees `usr_end`=1, and a read returns `usr_rdata` as sampled at that edge.
- R8: If `usr_end` is not seen within 64 edges after capture, the acknowledge appears after the 64th edge. A read then returns 0x00, and status bit 1 is set. Writing a 1 to status bit 1 clears it.
- R9: `usr_irq_req`=1 at an edge sets status bit 0, whatever the enable. Writing a 1 to status bit 0 clears it. `irq` = status bit 0 AND control bit 0 (offset 0x01).
- R10: `dout_oe` is 1 only in the acknowledge cycle of a read, and 0 during writes and idle cycles.
- R11: Offset 0x03 is a read/write register that drives `rb_addr`. Offset 0x04 reads the `rb_data` input.
- R12: While a user-window access is open, new requests are ignored. They write nothing and produce no acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_sel | input | 2 | Bus style select, sampled in reset |
| addr | input | 5 | Host address |
| din | input | 8 | Host write data |
| dout | output | 8 | Host read data |
| dout_oe | output | 1 | Read data valid / drive enable |
| ta_start | input | 1 | Transfer-start strobe |
| ta_rnw | input | 1 | Transfer-start read (1) / write (0) |
| ta_burst | input | 1 | Transfer-start burst flag |
| ta_ack | output | 1 | Transfer acknowledge |
| as_strobe | input | 1 | Address-strobe style access strobe |
| as_latch | input | 1 | Address latch enable |
| as_wnr | input | 1 | Address-strobe write (1) / read (0) |
| as_ready | output | 1 | Address-strobe ready |
| usr_start | output | 1 | User access start pulse |
| usr_wr | output | 1 | User access is a write |
| usr_addr | output | 4 | User register index |
| usr_wdata | output | 8 | User write data |
| usr_rdata | input | 8 | User read data |
| usr_end | input | 1 | User access end |
| usr_irq_req | input | 1 | User attention request |
| irq | output | 1 | Interrupt to host |
| rb_addr | output | 8 | Readback address register value |
| rb_data | input | 8 | Readback data |

## Verification

Timing is counted in edges after the capture edge:

| Result | Due |
|---|---|
| Acknowledge or ready for a dedicated register | 1 edge |
| Acknowledge for a user-window access whose user logic answers d cycles after seeing `usr_start` | d+2 edges |
| Acknowledge for an unanswered user-window access | 65 edges |
| Status, `irq` and `rb_addr` after a write or request | next edge |

The bench drives every input on falling edges. It counts falling edges from the one that follows the capture edge, so the first falling edge is count 1. Each access task checks that the acknowledge appears at exactly the expected count. The opposite protocol's acknowledge and a stray `dout_oe` are watched across the whole wait.

// File: rtl/hostreg_pkg.sv
package hostreg_pkg;

   typedef enum logic [1:0] {
      MODE_NONE = 2'b00,
      MODE_XFER = 2'b01,
      MODE_STRB = 2'b10,
      MODE_RSVD = 2'b11
   } host_mode_e;

   // dedicated register offsets (low address bits)
   localparam int OFS_STAT = 0;
   localparam int OFS_CTRL = 1;
   localparam int OFS_SCR  = 2;
   localparam int OFS_RBA  = 3;
   localparam int OFS_RBD  = 4;
   localparam int OFS_ID   = 5;

   // status bits
   localparam int ST_IRQ = 0;
   localparam int ST_TMO = 1;

endpackage

// File: rtl/hostreg_front.sv
module hostreg_front
   import hostreg_pkg::*;
#(
   parameter int ADDR_W = 5,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  host_mode_e        mode,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] din,
   input  logic              ta_start,
   input  logic              ta_rnw,
   input  logic              ta_burst,
   input  logic              as_strobe,
   input  logic              as_latch,
   input  logic              as_wnr,
   output logic              req_vld,
   output logic              req_wr,
   output logic              req_bad,
   output logic [ADDR_W-1:0] req_addr,
   output logic [DATA_W-1:0] req_wdata
);

   logic [ADDR_W-1:0] lat_q;

   always_ff @(posedge clk) begin
      if (!rst_n)        lat_q <= '0;
      else if (as_latch) lat_q <= addr;
   end

   always_comb begin
      req_vld   = 1'b0;
      req_wr    = 1'b0;
      req_bad   = 1'b0;
      req_addr  = addr;
      req_wdata = din;
      case (mode)
         MODE_XFER: begin
            req_vld = ta_start;
            req_wr  = ~ta_rnw;
            req_bad = ta_burst;
         end
         MODE_STRB: begin
            req_vld  = as_strobe;
            req_wr   = as_wnr;
            req_addr = as_latch ? addr : lat_q;
         end
         default: req_vld = 1'b0;
      endcase
   end

endmodule

// File: rtl/hostreg_regs.sv
module hostreg_regs
   import hostreg_pkg::*;
#(
   parameter int          DATA_W   = 8,
   parameter int          OFS_W    = 4,
   parameter int unsigned ID_VALUE = 'h3C
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [OFS_W-1:0]  sel_ofs,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              irq_req,
   input  logic              tmo_set,
   input  logic [DATA_W-1:0] rb_data,
   output logic [DATA_W-1:0] rd_data,
   output logic [DATA_W-1:0] rb_addr,
   output logic              irq
);

   logic              stat_irq, stat_tmo;
   logic [DATA_W-1:0] ctrl_q, scr_q, rba_q;
   logic              wr_stat;

   assign wr_stat = wr_en && (int'(sel_ofs) == OFS_STAT);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         stat_irq <= 1'b0;
         stat_tmo <= 1'b0;
         ctrl_q   <= '0;
         scr_q    <= '0;
         rba_q    <= '0;
      end else begin
         stat_irq <= irq_req | (stat_irq & ~(wr_stat & wr_data[ST_IRQ]));
         stat_tmo <= tmo_set | (stat_tmo & ~(wr_stat & wr_data[ST_TMO]));
         if (wr_en) begin
            case (int'(sel_ofs))
               OFS_CTRL: ctrl_q <= wr_data;
               OFS_SCR:  scr_q  <= wr_data;
               OFS_RBA:  rba_q  <= wr_data;
               default:  ;
            endcase
         end
      end
   end

   always_comb begin
      case (int'(sel_ofs))
         OFS_STAT: rd_data = {{(DATA_W-2){1'b0}}, stat_tmo, stat_irq};
         OFS_CTRL: rd_data = ctrl_q;
         OFS_SCR:  rd_data = scr_q;
         OFS_RBA:  rd_data = rba_q;
         OFS_RBD:  rd_data = rb_data;
         OFS_ID:   rd_data = DATA_W'(ID_VALUE);
         default:  rd_data = '0;
      endcase
   end

   assign rb_addr = rba_q;
   assign irq     = stat_irq & ctrl_q[0];

endmodule

// File: rtl/hostreg_usrhs.sv
module hostreg_usrhs #(
   parameter int DATA_W      = 8,
   parameter int USR_AW      = 4,
   parameter int TMO_CYC     = 64,
   parameter int SYNC_STAGES = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              go,
   input  logic              go_wr,
   input  logic [USR_AW-1:0] go_addr,
   input  logic [DATA_W-1:0] go_wdata,
   input  logic              usr_end,
   input  logic [DATA_W-1:0] usr_rdata,
   output logic              busy,
   output logic              usr_start,
   output logic              usr_wr,
   output logic [USR_AW-1:0] usr_addr,
   output logic [DATA_W-1:0] usr_wdata,
   output logic              done,
   output logic              done_rd,
   output logic [DATA_W-1:0] done_data,
   output logic              tmo
);

   localparam int CW = $clog2(TMO_CYC);

   logic          end_s;
   logic          busy_q, start_q, wr_q, last;
   logic [CW-1:0] cnt_q;

   generate
      if (SYNC_STAGES == 0) begin : g_end_direct
         assign end_s = usr_end;
      end else begin : g_end_sync
         logic [SYNC_STAGES-1:0] sh_q;
         always_ff @(posedge clk) begin
            if (!rst_n) sh_q <= '0;
            else        sh_q <= {sh_q[SYNC_STAGES-2:0], usr_end};
         end
         assign end_s = sh_q[SYNC_STAGES-1];
      end
   endgenerate

   assign last = (cnt_q == CW'(TMO_CYC - 1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q    <= 1'b0;
         start_q   <= 1'b0;
         wr_q      <= 1'b0;
         cnt_q     <= '0;
         usr_addr  <= '0;
         usr_wdata <= '0;
      end else begin
         start_q <= go;
         if (go) begin
            busy_q    <= 1'b1;
            cnt_q     <= '0;
            wr_q      <= go_wr;
            usr_addr  <= go_addr;
            usr_wdata <= go_wdata;
         end else if (busy_q) begin
            if (end_s || last) busy_q <= 1'b0;
            else               cnt_q  <= cnt_q + 1'b1;
         end
      end
   end

   assign busy      = busy_q;
   assign usr_start = start_q;
   assign usr_wr    = wr_q;
   assign done      = busy_q & (end_s | last);
   assign tmo       = busy_q & ~end_s & last;
   assign done_rd   = ~wr_q;
   assign done_data = end_s ? usr_rdata : '0;

endmodule

// File: rtl/hostreg_bridge.sv
module hostreg_bridge
   import hostreg_pkg::*;
#(
   parameter int          DATA_W          = 8,
   parameter int          ADDR_W          = 5,
   parameter int          USR_REGS        = 16,
   parameter int          TMO_CYC         = 64,
   parameter int unsigned ID_VALUE        = 'h3C,
   parameter int          END_SYNC_STAGES = 0
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [1:0]                  mode_sel,
   input  logic [ADDR_W-1:0]           addr,
   input  logic [DATA_W-1:0]           din,
   output logic [DATA_W-1:0]           dout,
   output logic                        dout_oe,
   input  logic                        ta_start,
   input  logic                        ta_rnw,
   input  logic                        ta_burst,
   output logic                        ta_ack,
   input  logic                        as_strobe,
   input  logic                        as_latch,
   input  logic                        as_wnr,
   output logic                        as_ready,
   output logic                        usr_start,
   output logic                        usr_wr,
   output logic [$clog2(USR_REGS)-1:0] usr_addr,
   output logic [DATA_W-1:0]           usr_wdata,
   input  logic [DATA_W-1:0]           usr_rdata,
   input  logic                        usr_end,
   input  logic                        usr_irq_req,
   output logic                        irq,
   output logic [DATA_W-1:0]           rb_addr,
   input  logic [DATA_W-1:0]           rb_data
);

   localparam int USR_AW = $clog2(USR_REGS);
   localparam int OFS_W  = ADDR_W - 1;

   generate
      if (ADDR_W != USR_AW + 1) begin : g_bad_aw
         $error("ADDR_W must be one bit wider than the user index");
      end
      if (DATA_W < 2) begin : g_bad_dw
         $error("DATA_W must hold the two status flags");
      end
      if (TMO_CYC < 2) begin : g_bad_tmo
         $error("TMO_CYC must be at least 2");
      end
      if (END_SYNC_STAGES == 1 || END_SYNC_STAGES < 0) begin : g_bad_sync
         $error("END_SYNC_STAGES must be 0 or at least 2");
      end
   endgenerate

   host_mode_e        mode_q;
   logic              req_vld, req_wr, req_bad;
   logic [ADDR_W-1:0] req_addr;
   logic [DATA_W-1:0] req_wdata, ded_rd, hs_data, dout_q;
   logic              busy, req_go, to_usr, usr_go, ded_go, ded_wr;
   logic              hs_done, hs_rd, hs_tmo, ack_q, oe_q;

   always_ff @(posedge clk) begin
      if (!rst_n) mode_q <= host_mode_e'(mode_sel);
      else        mode_q <= mode_q;
   end

   hostreg_front #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_front (
      .clk, .rst_n, .mode(mode_q), .addr, .din,
      .ta_start, .ta_rnw, .ta_burst, .as_strobe, .as_latch, .as_wnr,
      .req_vld, .req_wr, .req_bad, .req_addr, .req_wdata
   );

   assign req_go = req_vld & ~busy;
   assign to_usr = req_addr[ADDR_W-1] & ~req_bad;
   assign usr_go = req_go & to_usr;
   assign ded_go = req_go & ~to_usr;
   assign ded_wr = ded_go & req_wr & ~req_bad;

   hostreg_regs #(.DATA_W(DATA_W), .OFS_W(OFS_W), .ID_VALUE(ID_VALUE)) u_regs (
      .clk, .rst_n, .wr_en(ded_wr), .sel_ofs(req_addr[OFS_W-1:0]),
      .wr_data(req_wdata), .irq_req(usr_irq_req), .tmo_set(hs_tmo),
      .rb_data, .rd_data(ded_rd), .rb_addr, .irq
   );

   hostreg_usrhs #(
      .DATA_W(DATA_W), .USR_AW(USR_AW), .TMO_CYC(TMO_CYC),
      .SYNC_STAGES(END_SYNC_STAGES)
   ) u_usrhs (
      .clk, .rst_n, .go(usr_go), .go_wr(req_wr),
      .go_addr(req_addr[USR_AW-1:0]), .go_wdata(req_wdata),
      .usr_end, .usr_rdata, .busy, .usr_start, .usr_wr, .usr_addr,
      .usr_wdata, .done(hs_done), .done_rd(hs_rd), .done_data(hs_data),
      .tmo(hs_tmo)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ack_q  <= 1'b0;
         oe_q   <= 1'b0;
         dout_q <= '0;
      end else begin
         ack_q <= ded_go | hs_done;
         if (ded_go) begin
            oe_q   <= ~req_wr;
            dout_q <= (~req_wr & ~req_bad) ? ded_rd : '0;
         end else if (hs_done) begin
            oe_q   <= hs_rd;
            dout_q <= hs_rd ? hs_data : '0;
         end else begin
            oe_q   <= 1'b0;
            dout_q <= '0;
         end
      end
   end

   assign ta_ack   = ack_q & (mode_q == MODE_XFER);
   assign as_ready = ack_q & (mode_q == MODE_STRB);
   assign dout     = dout_q;
   assign dout_oe  = oe_q;

endmodule

// File: rtl/hostreg_bridge_chk.sv
module hostreg_bridge_chk #(
   parameter int TMO_CYC = 64
) (
   input logic       clk,
   input logic       rst_n,
   input logic [1:0] mode_q,
   input logic       ta_ack,
   input logic       as_ready,
   input logic       dout_oe,
   input logic       usr_start
);

   logic pend_q;
   int   wait_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
         wait_q <= 0;
      end else if (ta_ack || as_ready) begin
         pend_q <= 1'b0;
         wait_q <= 0;
      end else if (usr_start) begin
         pend_q <= 1'b1;
         wait_q <= 1;
      end else if (pend_q) begin
         wait_q <= wait_q + 1;
      end
   end

   // R1
   off_mode_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == 2'b00 || mode_q == 2'b11) |-> (!ta_ack && !as_ready && !dout_oe));

   // R2
   xfer_no_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == 2'b01) |-> !as_ready);

   // R3
   strb_no_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == 2'b10) |-> !ta_ack);

   // R10
   oe_with_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dout_oe |-> (ta_ack || as_ready));

   // R7
   start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      usr_start |=> !usr_start);

   // R8
   tmo_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pend_q |-> (wait_q <= TMO_CYC));

endmodule

bind hostreg_bridge hostreg_bridge_chk #(.TMO_CYC(TMO_CYC)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .mode_q    (mode_q),
   .ta_ack    (ta_ack),
   .as_ready  (as_ready),
   .dout_oe   (dout_oe),
   .usr_start (usr_start)
);

// File: tb/hostreg_bridge_tb_top.sv
`timescale 1ns/1ps
module hostreg_bridge_tb_top;

   localparam int XF = 0;
   localparam int SB = 1;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] mode_sel = 2'b01;
   logic [4:0] addr = '0;
   logic [7:0] din = '0;
   logic [7:0] dout;
   logic       dout_oe;
   logic       ta_start = 0, ta_rnw = 0, ta_burst = 0, ta_ack;
   logic       as_strobe = 0, as_latch = 0, as_wnr = 0, as_ready;
   logic       usr_start, usr_wr;
   logic [3:0] usr_addr;
   logic [7:0] usr_wdata;
   logic [7:0] usr_rdata = '0;
   logic       usr_end = 0, usr_irq_req = 0, irq;
   logic [7:0] rb_addr;
   logic [7:0] rb_data = '0;

   int n_chk = 0, n_fail = 0;
   bit finished = 0;

   // user-logic model
   logic [7:0] umem [16];
   bit         rsp_en = 1;
   int         rsp_dly = 0;
   int         n_start = 0;
   logic [3:0] seen_addr;
   logic       seen_wr;
   logic [7:0] seen_wd;

   always #2 clk = ~clk;

   hostreg_bridge dut_i (
      .clk, .rst_n, .mode_sel, .addr, .din, .dout, .dout_oe,
      .ta_start, .ta_rnw, .ta_burst, .ta_ack,
      .as_strobe, .as_latch, .as_wnr, .as_ready,
      .usr_start, .usr_wr, .usr_addr, .usr_wdata, .usr_rdata, .usr_end,
      .usr_irq_req, .irq, .rb_addr, .rb_data
   );

   initial begin
      for (int i = 0; i < 16; i++) umem[i] = 8'hE0 + 8'(i);
      forever begin
         @(negedge clk);
         if (usr_start === 1'b1) begin
            seen_addr = usr_addr;
            seen_wr   = usr_wr;
            seen_wd   = usr_wdata;
            n_start++;
            if (rsp_en) begin
               repeat (rsp_dly) @(negedge clk);
               usr_rdata = umem[seen_addr];
               if (seen_wr) umem[seen_addr] = seen_wd;
               usr_end = 1'b1;
               @(negedge clk);
               usr_end = 1'b0;
            end
         end
      end
   end

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic do_reset(input logic [1:0] m);
      @(negedge clk);
      mode_sel = m; rst_n = 0;
      ta_start = 0; as_strobe = 0; as_latch = 0; usr_irq_req = 0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
   endtask

   task automatic bus_acc(input int p, input bit wr, input logic [4:0] a,
                          input logic [7:0] wd, input bit burst, input bit same,
                          output logic [7:0] rd, output int lat,
                          output bit oe, output bit wrong);
      @(negedge clk);
      if (p == SB && !same) begin
         as_latch = 1; addr = a;
         @(negedge clk);
         as_latch = 0; addr = ~a;
      end
      din = wd;
      if (p == XF) begin
         ta_start = 1; ta_rnw = ~wr; ta_burst = burst; addr = a;
      end else begin
         as_strobe = 1; as_wnr = wr;
         if (same) begin as_latch = 1; addr = a; end
      end
      @(negedge clk);
      ta_start = 0; ta_burst = 0; as_strobe = 0; as_latch = 0;
      lat = -1; rd = 0; oe = 0; wrong = 0;
      for (int i = 1; i <= 120; i++) begin
         if ((p == XF) ? ta_ack : as_ready) begin
            lat = i; rd = dout; oe = dout_oe;
            if ((p == XF) ? as_ready : ta_ack) wrong = 1;
            break;
         end
         if (ta_ack || as_ready || dout_oe) wrong = 1;
         @(negedge clk);
      end
   endtask

   task automatic wr_reg(input int p, input logic [4:0] a, input logic [7:0] wd,
                         input string tag);
      logic [7:0] rd; int lat; bit oe, wrong;
      bus_acc(p, 1, a, wd, 0, 0, rd, lat, oe, wrong);
      chk({tag, " write latency"}, lat, 1);
      chk({tag, " R10 write oe"}, oe, 0);
      chk({tag, " stray strobe"}, wrong, 0);
   endtask

   task automatic rd_reg(input int p, input logic [4:0] a, input logic [7:0] exp,
                         input string tag);
      logic [7:0] rd; int lat; bit oe, wrong;
      bus_acc(p, 0, a, 0, 0, 0, rd, lat, oe, wrong);
      chk({tag, " read data"}, rd, exp);
      chk({tag, " read latency"}, lat, 1);
      chk({tag, " R10 read oe"}, oe, 1);
      chk({tag, " stray strobe"}, wrong, 0);
   endtask

   task automatic t_reset_state();
      do_reset(2'b01);
      chk("R1 reset ta_ack", ta_ack, 0);
      chk("R1 reset as_ready", as_ready, 0);
      chk("R10 reset dout_oe", dout_oe, 0);
      chk("R7 reset usr_start", usr_start, 0);
      chk("R9 reset irq", irq, 0);
      chk("R11 reset rb_addr", rb_addr, 0);
   endtask

   task automatic t_scratch();
      rd_reg(XF, 5'h02, 8'h00, "R4 scratch reset");
      wr_reg(XF, 5'h02, 8'h5A, "R2 R4");
      rd_reg(XF, 5'h02, 8'h5A, "R4 scratch 5A");
      wr_reg(XF, 5'h02, 8'hC3, "R4");
      rd_reg(XF, 5'h02, 8'hC3, "R4 scratch C3");
   endtask

   task automatic t_id();
      rd_reg(XF, 5'h05, 8'h3C, "R5 id");
      wr_reg(XF, 5'h05, 8'hFF, "R5");
      rd_reg(XF, 5'h05, 8'h3C, "R5 id after write");
   endtask

   task automatic t_unused_burst();
      logic [7:0] rd; int lat; bit oe, wrong;
      rd_reg(XF, 5'h06, 8'h00, "R6 offset 06");
      rd_reg(XF, 5'h0F, 8'h00, "R6 offset 0F");
      bus_acc(XF, 1, 5'h02, 8'h11, 1, 0, rd, lat, oe, wrong);
      chk("R6 burst write latency", lat, 1);
      rd_reg(XF, 5'h02, 8'hC3, "R6 scratch after burst write");
      bus_acc(XF, 0, 5'h02, 8'h00, 1, 0, rd, lat, oe, wrong);
      chk("R6 burst read data", rd, 0);
      chk("R6 burst read latency", lat, 1);
   endtask

   task automatic t_readback();
      wr_reg(XF, 5'h03, 8'h77, "R11");
      chk("R11 rb_addr port", rb_addr, 8'h77);
      rd_reg(XF, 5'h03, 8'h77, "R11 rb addr reg");
      rb_data = 8'h9E;
      rd_reg(XF, 5'h04, 8'h9E, "R11 rb data");
   endtask

   task automatic t_user();
      logic [7:0] rd; int lat; bit oe, wrong; int s0;
      rsp_en = 1; rsp_dly = 0; s0 = n_start;
      bus_acc(XF, 1, 5'h13, 8'hA5, 0, 0, rd, lat, oe, wrong);
      chk("R7 user write latency", lat, 2);
      chk("R7 one start pulse", n_start - s0, 1);
      chk("R7 usr_addr", seen_addr, 3);
      chk("R7 usr_wr", seen_wr, 1);
      chk("R7 usr_wdata", seen_wd, 8'hA5);
      rsp_dly = 5;
      bus_acc(XF, 0, 5'h13, 8'h00, 0, 0, rd, lat, oe, wrong);
      chk("R7 user read data", rd, 8'hA5);
      chk("R7 user read latency", lat, 7);
      chk("R7 R10 user read oe", oe, 1);
      chk("R7 usr_wr on read", seen_wr, 0);
      rsp_dly = 2;
      bus_acc(XF, 0, 5'h1F, 8'h00, 0, 0, rd, lat, oe, wrong);
      chk("R7 user reg 15 data", rd, 8'hEF);
      chk("R7 user reg 15 latency", lat, 4);
      chk("R7 usr_addr 15", seen_addr, 15);
      rsp_dly = 0;
   endtask

   task automatic t_timeout();
      logic [7:0] rd; int lat; bit oe, wrong;
      rsp_en = 0;
      bus_acc(XF, 0, 5'h12, 8'h00, 0, 0, rd, lat, oe, wrong);
      chk("R8 timeout latency", lat, 65);
      chk("R8 timeout data", rd, 0);
      chk("R8 timeout oe", oe, 1);
      rsp_en = 1;
      rd_reg(XF, 5'h00, 8'h02, "R8 status tmo set");
      wr_reg(XF, 5'h00, 8'h02, "R8");
      rd_reg(XF, 5'h00, 8'h00, "R8 status tmo cleared");
   endtask

   task automatic t_irq();
      @(negedge clk); usr_irq_req = 1;
      @(negedge clk); usr_irq_req = 0;
      chk("R9 irq masked", irq, 0);
      rd_reg(XF, 5'h00, 8'h01, "R9 pending flag");
      wr_reg(XF, 5'h01, 8'h01, "R9");
      chk("R9 irq enabled", irq, 1);
      wr_reg(XF, 5'h00, 8'h01, "R9");
      chk("R9 irq after clear", irq, 0);
      rd_reg(XF, 5'h00, 8'h00, "R9 pending cleared");
   endtask

   task automatic t_busy();
      int acks = 0;
      rsp_en = 1; rsp_dly = 10;
      @(negedge clk);
      ta_start = 1; ta_rnw = 1; addr = 5'h14;
      @(negedge clk);
      ta_start = 0;
      repeat (2) @(negedge clk);
      ta_start = 1; ta_rnw = 0; addr = 5'h02; din = 8'h33;
      @(negedge clk);
      ta_start = 0;
      for (int i = 0; i < 20; i++) begin
         if (ta_ack) acks++;
         @(negedge clk);
      end
      chk("R12 single ack", acks, 1);
      rsp_dly = 0;
      rd_reg(XF, 5'h02, 8'hC3, "R12 scratch untouched");
   endtask

   task automatic t_mode_hold();
      mode_sel = 2'b10;
      rd_reg(XF, 5'h02, 8'hC3, "R1 mode held after reset");
   endtask

   task automatic t_strobe();
      logic [7:0] rd; int lat; bit oe, wrong;
      do_reset(2'b10);
      wr_reg(SB, 5'h02, 8'h6B, "R3");
      rd_reg(SB, 5'h02, 8'h6B, "R3 latched address");
      bus_acc(SB, 0, 5'h05, 8'h00, 0, 1, rd, lat, oe, wrong);
      chk("R3 same-cycle latch data", rd, 8'h3C);
      chk("R3 same-cycle latency", lat, 1);
      bus_acc(XF, 1, 5'h02, 8'h99, 0, 0, rd, lat, oe, wrong);
      chk("R3 ta_start ignored", lat, -1);
      rd_reg(SB, 5'h02, 8'h6B, "R3 scratch after ignored start");
   endtask

   task automatic t_disabled();
      logic [7:0] rd; int lat; bit oe, wrong;
      do_reset(2'b00);
      bus_acc(XF, 0, 5'h05, 8'h00, 0, 0, rd, lat, oe, wrong);
      chk("R1 mode 00 xfer no ack", lat, -1);
      chk("R1 mode 00 no oe", wrong, 0);
      bus_acc(SB, 0, 5'h05, 8'h00, 0, 0, rd, lat, oe, wrong);
      chk("R1 mode 00 strobe no ready", lat, -1);
      do_reset(2'b11);
      bus_acc(XF, 0, 5'h05, 8'h00, 0, 0, rd, lat, oe, wrong);
      chk("R1 mode 11 xfer no ack", lat, -1);
      chk("R1 mode 11 no oe", wrong, 0);
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual running expected done");
      finish_run();
   end

   initial begin
      t_reset_state();
      t_scratch();
      t_id();
      t_unused_burst();
      t_readback();
      t_user();
      t_timeout();
      t_irq();
      t_busy();
      t_mode_hold();
      t_strobe();
      t_disabled();
      finish_run();
   end

endmodule